// File: doc/BRIEF.md
# Split-or-Chained Down-Counter Timer

This block is a general-purpose timer made of two byte-wide down-counter halves. Each half picks one of two clock sources, either a fast system tick or a 32768 Hz tick, and divides it by a factor chosen with a 3-bit code. When the halves run independently, each counts down to zero and then reloads from its own preset byte. When they are chained, the low half's settings drive one 16-bit counter, and the high half's enable, reload strobe and clock settings have no effect.

Software programs the block through an 8-bit write port that has eight register addresses. The live count is always present on an output. The block makes two single-cycle interrupt pulses. The primary pulse fires whenever the high half underflows. A build parameter selects what the secondary pulse signals: either a low-half underflow, or the counter moving into the "less than or equal to a comparator" condition.

Top module: `tmr_dual_down`

## Requirements
- R1: After reset, `count` is 0 and both interrupt outputs are low.
- R2: When a half uses the system tick (source bit 0), codes 0 through 7 advance it once every 2, 8, 32, 64, 128, 256, 1024 or 4096 ticks.
- R3: When a half uses the slow tick (source bit 1), code c advances it once every 2^c ticks.
- R4: A half advances only if three bits are all 1: its own run bit (bit 0 of its control register), the timer enable (bit 7 of register 0), and the input that enables its chosen oscillator. While any of the three is 0, the count holds and the half's divider phase returns to zero.
- R5: A write with bit 1 set to a half's control register (address 2 for low, 3 for high) loads that half from its preset (address 4 for low, 5 for high). The new value appears one cycle later and takes priority over counting.
- R6: Each half counts down. A half that advances from 0 reloads its preset instead of wrapping.
- R7: `irq_pri` is a one-cycle pulse. It rises together with the reloaded value in the cycle after the high half (or, when chained, the full 16-bit count) underflows.
- R8: When bit 7 of the low control register is set, the counter is 16 bits wide. It is advanced and reloaded only by the low half's settings. Writes to the high half's run bit, reload bit and clock settings are stored but have no effect.
- R9: When chained, the counter reloads only when the full 16-bit value underflows, and no low-half underflow event is produced.
- R10: With `SEC_KIND`=0, `irq_sec` pulses together with the reloaded low byte after a low-half underflow, and only in split mode.
- R11: With `SEC_KIND`=1, `irq_sec` pulses for one cycle, one cycle after the count enters "count <= comparator". The comparator is at addresses 6 and 7. When chained, all 16 bits are compared; when split, only the high byte of the count and the high byte of the comparator are compared. After reset the condition counts as already held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_sys | input | 1 | System oscillator tick enable |
| tick_slow | input | 1 | 32768 Hz tick enable |
| osc_sys_on | input | 1 | Enable for the system oscillator source |
| osc_slow_on | input | 1 | Enable for the slow oscillator source |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0/1 clock config (low/high), 2/3 control, 4/5 preset, 6/7 comparator |
| wr_data | input | HALF_W | Write data. Clock config: [2:0] code, [3] source, [7] timer enable (address 0 only). Control: [0] run, [1] reload, [7] chain (address 2 only) |
| count | output | 2*HALF_W | Current count, high half in the upper byte |
| irq_pri | output | 1 | Primary interrupt pulse |
| irq_sec | output | 1 | Secondary interrupt pulse, function set by SEC_KIND |

## Verification
The assertions rely on two things: the tick inputs are single-cycle enables sampled on the clock, and `wr_addr` and `wr_data` are valid whenever `wr_en` is high. The bench drives every input on the falling edge, and it drives each tick as a clean one-cycle level. The slow tick repeats every three cycles, which keeps it slower than the system tick, as it would be in a real system. Prescale codes and the chain bit change only through whole register writes, so the assertions never see a half-written setting.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CODE_W = 3;
  localparam int DIV_W  = 13;

  typedef enum logic [2:0] {
    A_CFG_LO = 3'd0, A_CFG_HI = 3'd1, A_CTL_LO = 3'd2, A_CTL_HI = 3'd3,
    A_PRE_LO = 3'd4, A_PRE_HI = 3'd5, A_CMP_LO = 3'd6, A_CMP_HI = 3'd7
  } reg_addr_e;

  typedef struct packed {
    logic              src;
    logic [CODE_W-1:0] code;
  } half_cfg_t;

  // Divide ratio for a source and code, as a power of two
  function automatic logic [DIV_W-1:0] prescale_div(input logic slow,
                                                    input logic [CODE_W-1:0] code);
    logic [3:0] sh;
    if (slow) begin
      sh = {1'b0, code};
    end else begin
      case (code)
        3'd0: sh = 4'd1;
        3'd1: sh = 4'd3;
        3'd2: sh = 4'd5;
        3'd3: sh = 4'd6;
        3'd4: sh = 4'd7;
        3'd5: sh = 4'd8;
        3'd6: sh = 4'd10;
        default: sh = 4'd12;
      endcase
    end
    return DIV_W'(1) << sh;
  endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import tmr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      run,
  input  logic      tick_sys,
  input  logic      tick_slow,
  input  half_cfg_t cfg,
  output logic      step
);
  logic [DIV_W-1:0] limit;
  logic [DIV_W-1:0] phase;
  logic             tick;
  logic             at_end;

  assign limit  = prescale_div(cfg.src, cfg.code);
  assign tick   = cfg.src ? tick_slow : tick_sys;
  assign at_end = (phase >= (limit - DIV_W'(1)));
  assign step   = run & tick & at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (!run) begin
      phase <= '0;
    end else if (tick) begin
      phase <= at_end ? '0 : phase + DIV_W'(1);
    end
  end

  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (phase == '0)); // R4
  AST_STEP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (phase == '0)); // R2
endmodule

// File: rtl/tmr_halves.sv
module tmr_halves #(
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chain,
  input  logic              step_lo,
  input  logic              step_hi,
  input  logic              load_lo,
  input  logic              load_hi,
  input  logic [HALF_W-1:0] preset_lo,
  input  logic [HALF_W-1:0] preset_hi,
  output logic [HALF_W-1:0] cnt_lo,
  output logic [HALF_W-1:0] cnt_hi,
  output logic              uf_lo,
  output logic              uf_hi
);
  localparam int FULL_W = 2 * HALF_W;

  logic [FULL_W-1:0] full;
  logic [FULL_W-1:0] full_pre;

  assign full     = {cnt_hi, cnt_lo};
  assign full_pre = {preset_hi, preset_lo};

  always_comb begin
    uf_lo = !chain && step_lo && !load_lo && (cnt_lo == '0);
    if (chain) uf_hi = step_lo && !load_lo && (full == '0);
    else       uf_hi = step_hi && !load_hi && (cnt_hi == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_lo <= '0;
      cnt_hi <= '0;
    end else if (chain) begin
      if (load_lo)
        {cnt_hi, cnt_lo} <= full_pre;
      else if (step_lo)
        {cnt_hi, cnt_lo} <= (full == '0) ? full_pre : full - FULL_W'(1);
    end else begin
      if (load_lo)      cnt_lo <= preset_lo;
      else if (step_lo) cnt_lo <= (cnt_lo == '0) ? preset_lo : cnt_lo - HALF_W'(1);
      if (load_hi)      cnt_hi <= preset_hi;
      else if (step_hi) cnt_hi <= (cnt_hi == '0) ? preset_hi : cnt_hi - HALF_W'(1);
    end
  end

  AST_SPLIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!chain && !step_lo && !load_lo) |=> $stable(cnt_lo)); // R4
  AST_HI_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (uf_hi && !chain) |=> (cnt_hi == $past(preset_hi))); // R6
  AST_FULL_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (uf_hi && chain) |=> ({cnt_hi, cnt_lo} == $past(full_pre))); // R9
  AST_HI_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (chain && !step_lo && !load_lo) |=> $stable(cnt_hi)); // R8
  AST_CHAIN_NO_LO: assert property (@(posedge clk) disable iff (!rst_n)
    chain |-> !uf_lo); // R9
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq #(
  parameter int HALF_W   = 8,
  parameter int SEC_KIND = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                chain,
  input  logic [2*HALF_W-1:0] cnt,
  input  logic [2*HALF_W-1:0] cmp,
  input  logic                uf_lo,
  input  logic                uf_hi,
  output logic                irq_pri,
  output logic                irq_sec
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_pri <= 1'b0;
    else        irq_pri <= uf_hi;
  end

  AST_PRI_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pri |-> $past(uf_hi)); // R7

  generate
    if (SEC_KIND == 0) begin : g_underflow
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_sec <= 1'b0;
        else        irq_sec <= uf_lo;
      end
      AST_SEC_SPLIT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        irq_sec |-> !$past(chain)); // R10
    end else begin : g_compare
      logic le_now;
      logic le_q;
      always_comb begin
        if (chain) le_now = (cnt <= cmp);
        else       le_now = (cnt[2*HALF_W-1:HALF_W] <= cmp[2*HALF_W-1:HALF_W]);
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          le_q    <= 1'b1;
          irq_sec <= 1'b0;
        end else begin
          le_q    <= le_now;
          irq_sec <= le_now & ~le_q;
        end
      end
      AST_SEC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_sec |=> !irq_sec); // R11
      AST_SEC_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        irq_sec |-> !$past(le_q)); // R11
    end
  endgenerate
endmodule

// File: rtl/tmr_dual_down.sv
module tmr_dual_down
  import tmr_pkg::*;
#(
  parameter int HALF_W   = 8,
  parameter int SEC_KIND = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_sys,
  input  logic                tick_slow,
  input  logic                osc_sys_on,
  input  logic                osc_slow_on,
  input  logic                wr_en,
  input  logic [2:0]          wr_addr,
  input  logic [HALF_W-1:0]   wr_data,
  output logic [2*HALF_W-1:0] count,
  output logic                irq_pri,
  output logic                irq_sec
);
  localparam int NHALF   = 2;
  localparam int TOP_BIT = HALF_W - 1;

  half_cfg_t         cfg_q [NHALF];
  logic [HALF_W-1:0] pre_q [NHALF];
  logic [HALF_W-1:0] cmp_q [NHALF];
  logic [NHALF-1:0]  run_q;
  logic              tmr_en_q;
  logic              chain_q;

  logic [NHALF-1:0]  run_eff;
  logic [NHALF-1:0]  step;
  logic [NHALF-1:0]  load;
  logic [HALF_W-1:0] cnt_lo, cnt_hi;
  logic              uf_lo, uf_hi;

  // Register file
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NHALF; i++) begin
        cfg_q[i] <= '0;
        pre_q[i] <= '0;
        cmp_q[i] <= '0;
      end
      run_q    <= '0;
      tmr_en_q <= 1'b0;
      chain_q  <= 1'b0;
    end else if (wr_en) begin
      case (reg_addr_e'(wr_addr))
        A_CFG_LO: begin
          cfg_q[0] <= half_cfg_t'(wr_data[CODE_W:0]);
          tmr_en_q <= wr_data[TOP_BIT];
        end
        A_CFG_HI: cfg_q[1] <= half_cfg_t'(wr_data[CODE_W:0]);
        A_CTL_LO: begin
          run_q[0] <= wr_data[0];
          chain_q  <= wr_data[TOP_BIT];
        end
        A_CTL_HI: run_q[1] <= wr_data[0];
        A_PRE_LO: pre_q[0] <= wr_data;
        A_PRE_HI: pre_q[1] <= wr_data;
        A_CMP_LO: cmp_q[0] <= wr_data;
        default:  cmp_q[1] <= wr_data;
      endcase
    end
  end

  // Reload strobes: the high strobe is dead while chained
  assign load[0] = wr_en && (reg_addr_e'(wr_addr) == A_CTL_LO) && wr_data[1];
  assign load[1] = wr_en && (reg_addr_e'(wr_addr) == A_CTL_HI) && wr_data[1] && !chain_q;

  generate
    for (genvar g = 0; g < NHALF; g++) begin : g_half
      logic osc_ok;
      assign osc_ok = cfg_q[g].src ? osc_slow_on : osc_sys_on;
      if (g == 0) begin : g_lo_run
        assign run_eff[g] = run_q[g] & tmr_en_q & osc_ok;
      end else begin : g_hi_run
        assign run_eff[g] = run_q[g] & tmr_en_q & osc_ok & ~chain_q;
      end
      tmr_prescale u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run_eff[g]),
        .tick_sys  (tick_sys),
        .tick_slow (tick_slow),
        .cfg       (cfg_q[g]),
        .step      (step[g])
      );
    end
  endgenerate

  tmr_halves #(.HALF_W(HALF_W)) u_halves (
    .clk       (clk),
    .rst_n     (rst_n),
    .chain     (chain_q),
    .step_lo   (step[0]),
    .step_hi   (step[1]),
    .load_lo   (load[0]),
    .load_hi   (load[1]),
    .preset_lo (pre_q[0]),
    .preset_hi (pre_q[1]),
    .cnt_lo    (cnt_lo),
    .cnt_hi    (cnt_hi),
    .uf_lo     (uf_lo),
    .uf_hi     (uf_hi)
  );

  assign count = {cnt_hi, cnt_lo};

  tmr_irq #(.HALF_W(HALF_W), .SEC_KIND(SEC_KIND)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .chain   (chain_q),
    .cnt     (count),
    .cmp     ({cmp_q[1], cmp_q[0]}),
    .uf_lo   (uf_lo),
    .uf_hi   (uf_hi),
    .irq_pri (irq_pri),
    .irq_sec (irq_sec)
  );

  AST_NO_STEP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_en_q && !load[0] && !chain_q) |=> $stable(cnt_lo)); // R4
  AST_RELOAD_LO: assert property (@(posedge clk) disable iff (!rst_n)
    load[0] |=> (cnt_lo == $past(pre_q[0]))); // R5
endmodule

// File: tb/test_tmr_dual_down.sv
module test_tmr_dual_down;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_sys = 1'b1, tick_slow = 1'b0;
  logic        osc_sys_on = 1'b0, osc_slow_on = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [15:0] count, count_b;
  logic        irq_pri, irq_sec, irq_pri_b, irq_sec_b;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  tmr_dual_down #(.HALF_W(8), .SEC_KIND(0)) i_tmr_dual_down (
    .clk(clk), .rst_n(rst_n), .tick_sys(tick_sys), .tick_slow(tick_slow),
    .osc_sys_on(osc_sys_on), .osc_slow_on(osc_slow_on), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .count(count),
    .irq_pri(irq_pri), .irq_sec(irq_sec));

  tmr_dual_down #(.HALF_W(8), .SEC_KIND(1)) i_tmr_dual_down_cmp (
    .clk(clk), .rst_n(rst_n), .tick_sys(tick_sys), .tick_slow(tick_slow),
    .osc_sys_on(osc_sys_on), .osc_slow_on(osc_slow_on), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .count(count_b),
    .irq_pri(irq_pri_b), .irq_sec(irq_sec_b));

  // Slow tick: one cycle in three
  int sl_cnt = 0;
  always @(negedge clk) begin
    sl_cnt    = (sl_cnt + 1) % 3;
    tick_slow = (sl_cnt == 0);
  end

  // Behavioural reference model
  int m_code[2], m_src[2], m_run[2], m_ph[2], m_pre[2], m_cnt[2];
  int m_ten, m_chain, m_cmp, m_le_prev;
  bit e_pri, e_sec0, e_sec1;
  int sys_sh[8] = '{1, 3, 5, 6, 7, 8, 10, 12};

  always @(posedge clk) begin
    int stp[2];
    int lim, full, pre16, le;
    bit ld0, ld1, act, tk;
    if (!rst_n) begin
      for (int h = 0; h < 2; h++) begin
        m_code[h] = 0; m_src[h] = 0; m_run[h] = 0; m_ph[h] = 0; m_pre[h] = 0; m_cnt[h] = 0;
      end
      m_ten = 0; m_chain = 0; m_cmp = 0; m_le_prev = 1;
      e_pri = 0; e_sec0 = 0; e_sec1 = 0;
    end else begin
      full  = m_cnt[1] * 256 + m_cnt[0];
      pre16 = m_pre[1] * 256 + m_pre[0];
      if (m_chain != 0) le = (full <= m_cmp) ? 1 : 0;
      else              le = (m_cnt[1] <= m_cmp / 256) ? 1 : 0;
      e_sec1    = (le == 1) && (m_le_prev == 0);
      m_le_prev = le;
      for (int h = 0; h < 2; h++) begin
        stp[h] = 0;
        act = (m_run[h] != 0) && (m_ten != 0) &&
              ((m_src[h] != 0) ? osc_slow_on : osc_sys_on) && !(h == 1 && m_chain != 0);
        tk  = (m_src[h] != 0) ? tick_slow : tick_sys;
        lim = (m_src[h] != 0) ? (1 << m_code[h]) : (1 << sys_sh[m_code[h]]);
        if (!act) m_ph[h] = 0;
        else if (tk) begin
          if (m_ph[h] >= lim - 1) begin m_ph[h] = 0; stp[h] = 1; end
          else m_ph[h] = m_ph[h] + 1;
        end
      end
      ld0 = wr_en && wr_addr == 3'd2 && wr_data[1];
      ld1 = wr_en && wr_addr == 3'd3 && wr_data[1] && m_chain == 0;
      e_pri = 0; e_sec0 = 0;
      if (m_chain != 0) begin
        if (ld0) full = pre16;
        else if (stp[0] != 0) begin
          if (full == 0) begin full = pre16; e_pri = 1; end
          else full = full - 1;
        end
        m_cnt[1] = full / 256; m_cnt[0] = full % 256;
      end else begin
        if (ld0) m_cnt[0] = m_pre[0];
        else if (stp[0] != 0) begin
          if (m_cnt[0] == 0) begin m_cnt[0] = m_pre[0]; e_sec0 = 1; end
          else m_cnt[0] = m_cnt[0] - 1;
        end
        if (ld1) m_cnt[1] = m_pre[1];
        else if (stp[1] != 0) begin
          if (m_cnt[1] == 0) begin m_cnt[1] = m_pre[1]; e_pri = 1; end
          else m_cnt[1] = m_cnt[1] - 1;
        end
      end
      if (wr_en) begin
        case (wr_addr)
          3'd0: begin m_code[0] = wr_data[2:0]; m_src[0] = wr_data[3]; m_ten = wr_data[7]; end
          3'd1: begin m_code[1] = wr_data[2:0]; m_src[1] = wr_data[3]; end
          3'd2: begin m_run[0] = wr_data[0]; m_chain = wr_data[7]; end
          3'd3: m_run[1] = wr_data[0];
          3'd4: m_pre[0] = wr_data;
          3'd5: m_pre[1] = wr_data;
          3'd6: m_cmp = (m_cmp / 256) * 256 + wr_data;
          default: m_cmp = (m_cmp % 256) + wr_data * 256;
        endcase
      end
    end
  end

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (count !== 16'(m_cnt[1] * 256 + m_cnt[0]) || count_b !== count ||
          irq_pri !== e_pri || irq_sec !== e_sec0 || irq_sec_b !== e_sec1) begin
        fails++;
        $display("FAIL %s model: count=%h/%h pri=%b sec0=%b sec1=%b expected count=%h pri=%b sec0=%b sec1=%b",
                 cur_req, count, count_b, irq_pri, irq_sec, irq_sec_b,
                 16'(m_cnt[1] * 256 + m_cnt[0]), e_pri, e_sec0, e_sec1);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Cycles between two successive pulses of a chosen output
  task automatic gap(input int which, output int g);
    int n = 0;
    g = -1;
    while (n < 20000 && !(which == 0 ? irq_sec : irq_pri)) begin @(negedge clk); n++; end
    @(negedge clk);
    n = 1;
    while (n < 20000 && !(which == 0 ? irq_sec : irq_pri)) begin @(negedge clk); n++; end
    g = n;
  endtask

  initial begin
    int g, snap, npri, nsec, nsecb;
    idle(4);
    chk(count == 16'h0 && !irq_pri && !irq_sec && !irq_sec_b, "R1", int'(count), 0);
    rst_n = 1'b1;
    idle(2);
    chk(count == 16'h0 && !irq_pri && !irq_sec, "R1", int'(count), 0);

    osc_sys_on = 1'b1; osc_slow_on = 1'b1;
    cur_req = "R5";
    wr(4, 3); wr(5, 2);
    wr(0, 8'h82); wr(1, 8'h00);
    wr(2, 3); wr(3, 3);
    chk(count[15:8] == 8'd2, "R5 high reload", int'(count[15:8]), 2);

    cur_req = "R2";
    gap(0, g);
    chk(g == 128, "R2 sys code 2 low period / R10", g, 128);
    cur_req = "R7";
    gap(1, g);
    chk(g == 6, "R7 primary period", g, 6);
    chk(count[15:8] == 8'd2, "R6 reload with R7 pulse", int'(count[15:8]), 2);
    gap(0, g);
    chk(count[7:0] == 8'd3, "R10 low reload with pulse", int'(count[7:0]), 3);

    cur_req = "R4";
    osc_sys_on = 1'b0;
    idle(1);
    snap = int'(count);
    idle(40);
    chk(int'(count) == snap, "R4 osc off hold", int'(count), snap);
    osc_sys_on = 1'b1;
    wr(0, 8'h02); wr(1, 8'h00);
    idle(1);
    snap = int'(count);
    idle(40);
    chk(int'(count) == snap, "R4 timer enable off hold", int'(count), snap);

    cur_req = "R3";
    wr(4, 1); wr(0, 8'h89); wr(2, 3);
    gap(0, g);
    chk(g == 12, "R3 slow code 1 period", g, 12);

    cur_req = "R2";
    for (int c = 0; c < 8; c++) begin
      wr(0, 8'h80 | c); wr(2, 3);
      idle(c < 6 ? 600 : 9000);
    end

    cur_req = "R8";
    osc_sys_on = 1'b0;
    wr(4, 2); wr(5, 1); wr(0, 8'h80); wr(1, 8'h0F); wr(3, 0);
    wr(2, 8'h83);
    chk(count == 16'h0102, "R8 chained reload", int'(count), 16'h0102);
    wr(5, 8'h55); wr(3, 3);
    chk(count == 16'h0102, "R8 high reload ignored", int'(count), 16'h0102);
    wr(5, 1);
    osc_sys_on = 1'b1;

    cur_req = "R9";
    npri = 0; nsec = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (irq_pri) begin
        npri++;
        chk(count == 16'h0102, "R9 full reload", int'(count), 16'h0102);
      end
      if (irq_sec) nsec++;
    end
    chk(npri >= 5, "R9 full underflow pulses", npri, 5);
    chk(nsec == 0, "R9 no low pulse chained", nsec, 0);

    cur_req = "R11";
    wr(6, 8'h80); wr(7, 8'h00);
    nsecb = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (irq_sec_b) nsecb++;
    end
    chk(nsecb >= 3, "R11 chained compare pulses", nsecb, 3);
    wr(2, 3); wr(1, 8'h00); wr(5, 9); wr(7, 4); wr(3, 3);
    nsecb = 0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (irq_sec_b) nsecb++;
    end
    chk(nsecb >= 3, "R11 high byte compare pulses", nsecb, 3);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule